// File: doc/BRIEF.md
# Banked Binary Point Register Controller

This block holds the 3-bit binary point that divides an 8-bit interrupt priority into a preemption group part and a subpriority part. When a third privilege level exists it keeps two copies, one per security state; otherwise it keeps one. Every read or write request arrives in one cycle together with its privilege level and a set of routing controls. The block decides whether the request reaches a stored copy, is sent on to a virtual copy held elsewhere, traps to a named level, or is undefined. It answers one cycle later.

Writes below a copy's floor store the floor. The floor of the secure copy equals the companion group-0 floor `G0_MIN`. The floor of the non-secure copy is one higher, capped at 7. In common-point mode, non-secure level-1 and level-2 requests do not use the non-secure copy. Their reads return the companion group-0 value plus one, capped at 7, and their writes are dropped.

A two-state controller sequences the block. After reset it sits in `ST_INIT` for one cycle, with `ready` low and all requests ignored. It then takes the only transition, *init_done*, into `ST_RUN`, where it stays until the next reset. In `ST_RUN` every cycle with `req_rd` or `req_wr` high is an accepted request.

Top module: `bp_ctrl`

## Requirements
- R1: After reset both copies hold their floors: secure reads `G0_MIN` (2 by default) and non-secure reads `G0_MIN+1` (3). `ready` is low during reset and during the one `ST_INIT` cycle that follows it.
- R2: Read data bits [63:3] are always zero. Write data bits [63:3] are ignored, and only bits [2:0] are stored.
- R3: A non-secure write whose value is below the non-secure floor stores the floor. Any other value is stored unchanged.
- R4: A secure write whose value is below `G0_MIN` stores `G0_MIN`.
- R5: A request at level 0 is answered with code 3 (undefined) and changes no copy.
- R6: At level 1 the checks apply in this order, and the first match wins:
  - interface enable 0 gives trap (code 2) to level 1;
  - level 2 on with trap-all set gives trap to level 2;
  - level 2 on with hypervisor IRQ routing set gives code 1 (virtual);
  - level 3 present with top-level IRQ routing set gives trap to level 3;
  - otherwise the copy selected by `sec_ns` is used, with code 0.
- R7: At level 2 the checks apply in this order:
  - interface enable 0 gives trap to level 2;
  - top-level IRQ routing set with level 3 present gives trap to level 3;
  - otherwise the copy selected by `sec_ns` is used.
- R8: At level 3, interface enable 0 gives trap to level 3. Otherwise the request uses the secure copy when `sec_ns`=0 and the non-secure copy when `sec_ns`=1.
- R9: When common-point mode is on, a granted non-secure request at level 1 or 2 behaves as follows:
  - a read returns `grp0_bp+1`, saturated at 7;
  - a write changes no copy.
  
  When level 3 is present, the mode comes from `common_ns_l3`, and `common_l1` is not used.
- R10: Trap, undefined and virtual responses return zero read data and leave both copies unchanged.
- R11: `rsp_vld` is high in exactly the cycle after an accepted request. `rsp_lvl` is non-zero only on a trap, and write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request (wins if both are set) |
| req_lvl | input | 2 | Requesting privilege level 0..3 |
| req_wdata | input | 64 | Write data |
| sec_ns | input | 1 | Security state, 1 = non-secure |
| if_en_l1 | input | 1 | Register interface enable, level 1 |
| if_en_l2 | input | 1 | Register interface enable, level 2 |
| if_en_l3 | input | 1 | Register interface enable, level 3 |
| l2_on | input | 1 | Level 2 enabled |
| hyp_irq | input | 1 | Hypervisor IRQ routing |
| top_irq | input | 1 | Top-level IRQ routing |
| trap_all | input | 1 | Trap all level-1 requests to level 2 |
| common_ns_l3 | input | 1 | Common-point mode control, level-3 owner |
| common_l1 | input | 1 | Common-point mode control when level 3 is absent |
| grp0_bp | input | 3 | Companion group-0 binary point |
| ready | output | 1 | High in `ST_RUN` |
| rsp_vld | output | 1 | Response valid |
| rsp_code | output | 2 | 0 ok, 1 virtual, 2 trap, 3 undefined |
| rsp_lvl | output | 2 | Trap target level |
| rsp_rdata | output | 64 | Read data |

## Verification
Some properties are checked on every cycle by assertions:
- responses line up one-to-one with accepted requests;
- level 0 always gets code 3;
- a trap always names a non-zero level;
- the upper read bits stay zero;
- neither copy ever drops below its floor;
- a cycle without a write enable leaves both copies unchanged.

Other behaviours need the bench's sweep. These are the priority order of the routing checks, the selection between copies, clamping of each written value, aliasing with saturation, and whether a dropped write really left both copies untouched. After every write the bench reads back both copies at level 3.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        RC_OK    = 2'd0,
        RC_VIRT  = 2'd1,
        RC_TRAP  = 2'd2,
        RC_UNDEF = 2'd3
    } rsp_code_e;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        rsp_code_e  code;
        logic [1:0] tgt;
        logic       sel_ns;
        logic       use_g0;
    } route_t;

endpackage

// File: rtl/bp_route.sv
module bp_route
    import bp_pkg::*;
#(
    parameter bit HAS_L3 = 1'b1
) (
    input  logic [1:0] lvl,
    input  logic       ns,
    input  logic       en1,
    input  logic       en2,
    input  logic       en3,
    input  logic       l2_on,
    input  logic       hyp_irq,
    input  logic       top_irq,
    input  logic       trap_all,
    input  logic       common_l3,
    input  logic       common_l1,
    output route_t     rt
);

    logic top_trap;
    logic common;
    logic bank_ns;

    always_comb begin
        top_trap = HAS_L3 && top_irq;
        common   = HAS_L3 ? common_l3 : common_l1;
        bank_ns  = HAS_L3 ? ns : 1'b1;
        rt        = '0;
        rt.code   = RC_OK;
        rt.sel_ns = bank_ns;
        unique case (lvl)
            2'd0: rt.code = RC_UNDEF;
            2'd1: begin
                if (!en1) begin
                    rt.code = RC_TRAP; rt.tgt = 2'd1;
                end else if (l2_on && trap_all) begin
                    rt.code = RC_TRAP; rt.tgt = 2'd2;
                end else if (l2_on && hyp_irq) begin
                    rt.code = RC_VIRT;
                end else if (top_trap) begin
                    rt.code = RC_TRAP; rt.tgt = 2'd3;
                end else begin
                    rt.use_g0 = bank_ns && common;
                end
            end
            2'd2: begin
                if (!en2) begin
                    rt.code = RC_TRAP; rt.tgt = 2'd2;
                end else if (top_trap) begin
                    rt.code = RC_TRAP; rt.tgt = 2'd3;
                end else begin
                    rt.use_g0 = bank_ns && common;
                end
            end
            default: begin
                if (!HAS_L3) begin
                    rt.code = RC_UNDEF;
                end else if (!en3) begin
                    rt.code = RC_TRAP; rt.tgt = 2'd3;
                end
            end
        endcase
    end

endmodule

// File: rtl/bp_bank.sv
module bp_bank #(
    parameter int BPW    = 3,
    parameter int G0_MIN = 2,
    parameter bit HAS_L3 = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_ns,
    input  logic [BPW-1:0] wr_val,
    output logic [BPW-1:0] val_s,
    output logic [BPW-1:0] val_ns
);

    localparam int MAXV     = (1 << BPW) - 1;
    localparam int MIN_NS_I = (G0_MIN + 1 > MAXV) ? MAXV : G0_MIN + 1;
    localparam logic [BPW-1:0] MIN_S  = G0_MIN[BPW-1:0];
    localparam logic [BPW-1:0] MIN_NS = MIN_NS_I[BPW-1:0];

    logic [BPW-1:0] clamp_s;
    logic [BPW-1:0] clamp_ns;

    assign clamp_s  = (wr_val < MIN_S)  ? MIN_S  : wr_val;
    assign clamp_ns = (wr_val < MIN_NS) ? MIN_NS : wr_val;

    generate
        if (HAS_L3) begin : g_banked
            logic [BPW-1:0] cp_s;
            logic [BPW-1:0] cp_ns;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cp_s  <= MIN_S;
                    cp_ns <= MIN_NS;
                end else if (wr_en) begin
                    if (wr_ns) cp_ns <= clamp_ns;
                    else       cp_s  <= clamp_s;
                end
            end
            assign val_s  = cp_s;
            assign val_ns = cp_ns;
        end else begin : g_single
            logic [BPW-1:0] cp;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     cp <= MIN_NS;
                else if (wr_en) cp <= wr_ns ? clamp_ns : clamp_ns;
            end
            assign val_s  = cp;
            assign val_ns = cp;
        end
    endgenerate

    // R3: non-secure copy never below its floor
    p_floor_ns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        val_ns >= MIN_NS);

    // R4: secure copy never below its floor
    p_floor_s_r4: assert property (@(posedge clk) disable iff (!rst_n)
        val_s >= MIN_S);

    // R10: no write enable, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(val_s) && $stable(val_ns)));

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
    import bp_pkg::*;
#(
    parameter int DW     = 64,
    parameter int BPW    = 3,
    parameter int G0_MIN = 2,
    parameter bit HAS_L3 = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_rd,
    input  logic          req_wr,
    input  logic [1:0]    req_lvl,
    input  logic [DW-1:0] req_wdata,
    input  logic          sec_ns,
    input  logic          if_en_l1,
    input  logic          if_en_l2,
    input  logic          if_en_l3,
    input  logic          l2_on,
    input  logic          hyp_irq,
    input  logic          top_irq,
    input  logic          trap_all,
    input  logic          common_ns_l3,
    input  logic          common_l1,
    input  logic [BPW-1:0] grp0_bp,
    output logic          ready,
    output logic          rsp_vld,
    output logic [1:0]    rsp_code,
    output logic [1:0]    rsp_lvl,
    output logic [DW-1:0] rsp_rdata
);

    ctl_state_e     state_q;
    ctl_state_e     state_d;
    route_t         rt;
    logic           acc;
    logic           wr_en;
    logic [BPW-1:0] val_s;
    logic [BPW-1:0] val_ns;
    logic [BPW:0]   g0_inc;
    logic [BPW-1:0] g0_sat;
    logic [BPW-1:0] rd_val;
    rsp_code_e      code_q;
    logic [1:0]     lvl_q;
    logic           vld_q;
    logic [DW-1:0]  rdata_q;

    bp_route #(.HAS_L3(HAS_L3)) u_route (
        .lvl(req_lvl), .ns(sec_ns),
        .en1(if_en_l1), .en2(if_en_l2), .en3(if_en_l3),
        .l2_on(l2_on), .hyp_irq(hyp_irq), .top_irq(top_irq),
        .trap_all(trap_all), .common_l3(common_ns_l3),
        .common_l1(common_l1), .rt(rt)
    );

    bp_bank #(.BPW(BPW), .G0_MIN(G0_MIN), .HAS_L3(HAS_L3)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ns(rt.sel_ns),
        .wr_val(req_wdata[BPW-1:0]), .val_s(val_s), .val_ns(val_ns)
    );

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = ST_RUN;   // init_done
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    assign ready = (state_q == ST_RUN);
    assign acc   = ready && (req_rd || req_wr);
    assign wr_en = acc && req_wr && (rt.code == RC_OK) && !rt.use_g0;

    assign g0_inc = {1'b0, grp0_bp} + 1'b1;
    assign g0_sat = g0_inc[BPW] ? {BPW{1'b1}} : g0_inc[BPW-1:0];
    assign rd_val = rt.use_g0 ? g0_sat : (rt.sel_ns ? val_ns : val_s);

    // controller: response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            code_q  <= RC_OK;
            lvl_q   <= 2'd0;
            rdata_q <= '0;
        end else begin
            vld_q   <= acc;
            code_q  <= acc ? rt.code : RC_OK;
            lvl_q   <= (acc && rt.code == RC_TRAP) ? rt.tgt : 2'd0;
            rdata_q <= (acc && !req_wr && rt.code == RC_OK)
                       ? {{(DW-BPW){1'b0}}, rd_val} : '0;
        end
    end

    assign rsp_vld   = vld_q;
    assign rsp_code  = code_q;
    assign rsp_lvl   = lvl_q;
    assign rsp_rdata = rdata_q;

    // R11: a response follows exactly the accepted requests
    p_rsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_vld);
    p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_vld);

    // R5: level 0 is undefined
    p_lvl0_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_lvl == 2'd0) |=> (rsp_code == 2'd3));

    // R11: trap responses name a level
    p_trap_lvl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_code == 2'd2) |-> (rsp_lvl != 2'd0));

    // R2: upper read bits are zero
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[DW-1:BPW] == '0);

endmodule

// File: tb/bp_ctrl_tb.sv
`timescale 1ns/1ps
module bp_ctrl_tb;

    localparam int MIN_S  = 2;
    localparam int MIN_NS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [1:0]  req_lvl = 2'd0;
    logic [63:0] req_wdata = '0;
    logic        sec_ns = 1'b0, if_en_l1 = 1'b0, if_en_l2 = 1'b0, if_en_l3 = 1'b0;
    logic        l2_on = 1'b0, hyp_irq = 1'b0, top_irq = 1'b0, trap_all = 1'b0;
    logic        common_ns_l3 = 1'b0, common_l1 = 1'b0;
    logic [2:0]  grp0_bp = 3'd0;
    logic        ready, rsp_vld;
    logic [1:0]  rsp_code, rsp_lvl;
    logic [63:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [68:0] got;
    int m_s, m_ns;

    always #4 clk = ~clk;

    bp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_lvl(req_lvl), .req_wdata(req_wdata), .sec_ns(sec_ns),
        .if_en_l1(if_en_l1), .if_en_l2(if_en_l2), .if_en_l3(if_en_l3),
        .l2_on(l2_on), .hyp_irq(hyp_irq), .top_irq(top_irq),
        .trap_all(trap_all), .common_ns_l3(common_ns_l3),
        .common_l1(common_l1), .grp0_bp(grp0_bp), .ready(ready),
        .rsp_vld(rsp_vld), .rsp_code(rsp_code), .rsp_lvl(rsp_lvl),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [68:0] act, input logic [68:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic rd, input logic wr, input logic [1:0] lvl,
                        input logic [63:0] d);
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_lvl = lvl; req_wdata = d;
        @(negedge clk);
        got = {rsp_vld, rsp_code, rsp_lvl, rsp_rdata};
        req_rd = 1'b0; req_wr = 1'b0;
    endtask

    function automatic logic [68:0] rsp(input int code, input int lvl, input int data);
        return {1'b1, code[1:0], lvl[1:0], 61'd0, data[2:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {68'd0, ready}, 69'd0);
        // release reset with a request present during ST_INIT
        rst_n = 1'b1;
        if_en_l3 = 1'b1; sec_ns = 1'b0;
        req_wr = 1'b1; req_lvl = 2'd3; req_wdata = 64'd7;
        @(negedge clk);
        chk("R11 ignored in init", {67'd0, ready, rsp_vld}, {67'd0, 1'b1, 1'b0});
        req_wr = 1'b0;
        xfer(1'b1, 1'b0, 2'd3, '0);
        chk("R1 secure floor", got, rsp(0, 0, MIN_S));
        sec_ns = 1'b1;
        xfer(1'b1, 1'b0, 2'd3, '0);
        chk("R1 non-secure floor", got, rsp(0, 0, MIN_NS));
        m_s = MIN_S; m_ns = MIN_NS;

        for (int c = 0; c < 128; c++) begin
            for (int lv = 0; lv < 4; lv++) begin
                for (int v = 0; v < 8; v++) begin
                    int code, tl, rdv, ex_s, ex_ns, sel_val;
                    logic en, l2, hy, tp, ta, ns, cm, g0;
                    string tag;
                    en = c[0]; l2 = c[1]; hy = c[2]; tp = c[3];
                    ta = c[4]; ns = c[5]; cm = c[6];
                    code = 0; tl = 0; g0 = 1'b0;
                    case (lv)
                        0: code = 3;
                        1: begin
                            if (!en)           begin code = 2; tl = 1; end
                            else if (l2 && ta) begin code = 2; tl = 2; end
                            else if (l2 && hy) code = 1;
                            else if (tp)       begin code = 2; tl = 3; end
                            else g0 = ns && cm;
                        end
                        2: begin
                            if (!en)     begin code = 2; tl = 2; end
                            else if (tp) begin code = 2; tl = 3; end
                            else g0 = ns && cm;
                        end
                        default: if (!en) begin code = 2; tl = 3; end
                    endcase
                    tag = (lv == 0) ? "R5" : (lv == 1) ? "R6" : (lv == 2) ? "R7" : "R8";
                    if (code != 0) tag = {tag, "/R10"};
                    if (g0) tag = {tag, "/R9"};

                    sec_ns = ns; if_en_l1 = en; if_en_l2 = en; if_en_l3 = en;
                    l2_on = l2; hyp_irq = hy; top_irq = tp; trap_all = ta;
                    common_ns_l3 = cm; common_l1 = ~cm; grp0_bp = v[2:0];

                    ex_s = m_s; ex_ns = m_ns;
                    if (code == 0 && !g0) begin
                        if (ns) ex_ns = (v < MIN_NS) ? MIN_NS : v;
                        else    ex_s  = (v < MIN_S)  ? MIN_S  : v;
                    end
                    xfer(1'b0, 1'b1, lv[1:0], {32'hDEADBEEF, 29'h15555555, v[2:0]});
                    chk({tag, " write rsp R11"}, got, rsp(code, tl, 0));
                    m_s = ex_s; m_ns = ex_ns;

                    sel_val = ns ? m_ns : m_s;
                    rdv = (code != 0) ? 0 : g0 ? ((v + 1 > 7) ? 7 : v + 1) : sel_val;
                    xfer(1'b1, 1'b0, lv[1:0], 64'hFFFF_FFFF_FFFF_FFF8);
                    chk({tag, " read rsp R2"}, got, rsp(code, tl, rdv));

                    if_en_l3 = 1'b1;
                    sec_ns = 1'b0;
                    xfer(1'b1, 1'b0, 2'd3, '0);
                    chk({tag, " secure copy R4"}, got, rsp(0, 0, m_s));
                    sec_ns = 1'b1;
                    xfer(1'b1, 1'b0, 2'd3, '0);
                    chk({tag, " non-secure copy R3"}, got, rsp(0, 0, m_ns));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule